// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This controller connects a simple internal load/store port to slow external memory over eight shared lines. Those lines first carry the low address byte, which an external transparent latch captures when the latch-enable strobe falls. The same lines then carry the data. The high address byte has dedicated outputs, and there are separate active-low read and write strobes. The shared lines are modelled as split pins: a drive value, an output enable and an input sample.

Each access goes through a fixed set of named states:

- `S_IDLE` moves to `S_ADDR` when a request is accepted.
- `S_ADDR` raises the latch enable and drives the low address.
- `S_LATCH` lowers the latch enable and keeps driving the address as a hold phase.
- `S_STRB` holds the read or write strobe low for one cycle plus the wait extension.
- `S_HOLD` is optional. It adds one cycle with the strobe released while the address is still held.
- `S_DONE` pulses ready for one cycle and then returns to `S_IDLE`.

A two-bit wait code sets the wait extension. The code is picked per access by comparing the high address byte with a sector boundary, so two devices with different timing can share the bus. A bus-keeper output reports the last value seen on the shared lines whenever the controller has released them. Pull-up enables follow a port value while the lines are released.

Top module: `xbus_ctrl`

## Requirements
- R1: While `rst_n` is low and right after reset, the outputs are idle: `ale`=0, `rd_n`=1, `wr_n`=1, `ad_oe`=0 and `req_ready`=0.
- R2: The first cycle after a request is accepted has `ale`=1, `ad_oe`=1, `ad_o`=address bits [7:0] and `addr_hi`=address bits [15:8]. The next cycle has `ale`=0 while the same low address is still driven.
- R3: During a write strobe (`wr_n`=0), `ad_oe`=1 and `ad_o` carries the write data. `rd_n` and `wr_n` are never low together.
- R4: While `rd_n`=0 the shared lines are released (`ad_oe`=0). The value on `ad_i` in the last strobe cycle is returned on `req_rdata` in the ready cycle.
- R5: A wait code of 0, 1, 2 or 3 holds the strobe low for 1, 2, 3 or 3 cycles. Code 3 adds one cycle, with both strobes high, before ready.
- R6: An access whose address bits [15:8] are below `cfg_limit` uses `cfg_ws_lo`. Every other access uses `cfg_ws_hi`, so a limit of 0 sends every access to the upper code.
- R7: `req_ready` is high for exactly one cycle per access. It comes 3 + extra + tail cycles after the latch-enable cycle, where extra is 0/1/2/2 and tail is 1 only for code 3.
- R8: With `cfg_keep_en`=1 and `ad_oe`=0, `ad_keep_en`=1 and `ad_keep` holds the last value driven on `ad_o` or captured from `ad_i`. With `cfg_keep_en`=0, `ad_keep_en`=0.
- R9: `ad_pu` equals `cfg_pullup` while `ad_oe`=0 and is zero while the controller drives the lines.
- R10: A request is accepted only in `S_IDLE`. A request held high across a completion starts one cycle after the ready cycle, and requests complete in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present; held until ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | One-cycle completion pulse |
| req_rdata | output | 8 | Read data, valid with ready |
| cfg_limit | input | 8 | Sector boundary on address bits [15:8] |
| cfg_ws_lo | input | 2 | Wait code for the lower sector |
| cfg_ws_hi | input | 2 | Wait code for the upper sector |
| cfg_keep_en | input | 1 | Bus-keeper enable |
| cfg_pullup | input | 8 | Pull-up request per shared line |
| ad_o | output | 8 | Value driven on the shared lines |
| ad_oe | output | 1 | Drive enable for the shared lines |
| ad_i | input | 8 | Value sampled from the shared lines |
| addr_hi | output | 8 | High address byte |
| ale | output | 1 | Address latch enable, active high |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| ad_keep | output | 8 | Value held by the bus-keeper |
| ad_keep_en | output | 1 | Keeper is holding the lines |
| ad_pu | output | 8 | Pull-up enables |

## Verification
The assertions assume the requester follows the handshake: `req_valid` and the request fields stay steady from acceptance until ready. They also assume that `ad_i` carries the external device's data for the whole strobe. The bench drives every request at the falling clock edge and keeps it unchanged until it sees ready. It holds `ad_i` at the expected read value for the whole access, and it changes the configuration only while the controller is idle.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ADDR,
        S_LATCH,
        S_STRB,
        S_HOLD,
        S_DONE
    } xbus_state_e;

    typedef struct packed {
        logic [1:0] extra;
        logic       tail;
    } ws_plan_t;

    function automatic ws_plan_t decode_ws(input logic [1:0] code);
        ws_plan_t p;
        p.extra = (code == 2'd0) ? 2'd0 : ((code == 2'd1) ? 2'd1 : 2'd2);
        p.tail  = (code == 2'd3);
        return p;
    endfunction

endpackage

// File: rtl/xbus_sector_sel.sv
module xbus_sector_sel
    import xbus_pkg::*;
#(
    parameter int HW       = 8,
    parameter bit SPLIT_EN = 1'b1
) (
    input  logic [HW-1:0] addr_hi,
    input  logic [HW-1:0] limit,
    input  logic [1:0]    code_lo,
    input  logic [1:0]    code_hi,
    output ws_plan_t      plan
);

    generate
        if (SPLIT_EN) begin : g_split
            always_comb begin
                plan = decode_ws((addr_hi < limit) ? code_lo : code_hi);
            end
        end else begin : g_flat
            logic [HW-1:0] unused_bits;
            always_comb begin
                unused_bits = addr_hi ^ limit;
                plan = decode_ws(code_lo ^ (code_hi & 2'b00));
            end
        end
    endgenerate

endmodule

// File: rtl/xbus_keeper.sv
module xbus_keeper #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          drive_en,
    input  logic [DW-1:0] drive_val,
    input  logic          cap_en,
    input  logic [DW-1:0] cap_val,
    input  logic          keep_en,
    output logic [DW-1:0] hold_val,
    output logic          hold_en
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_val <= '0;
        end else if (drive_en) begin
            hold_val <= drive_val;
        end else if (cap_en) begin
            hold_val <= cap_val;
        end
    end

    always_comb begin
        hold_en = keep_en & ~drive_en;
    end

    // R8
    keep_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drive_en |=> (hold_val == $past(drive_val)));

endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
    import xbus_pkg::*;
#(
    parameter int AW       = 16,
    parameter int DW       = 8,
    parameter bit SPLIT_EN = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [AW-1:0]    req_addr,
    input  logic [DW-1:0]    req_wdata,
    output logic             req_ready,
    output logic [DW-1:0]    req_rdata,
    input  logic [AW-DW-1:0] cfg_limit,
    input  logic [1:0]       cfg_ws_lo,
    input  logic [1:0]       cfg_ws_hi,
    input  logic             cfg_keep_en,
    input  logic [DW-1:0]    cfg_pullup,
    output logic [DW-1:0]    ad_o,
    output logic             ad_oe,
    input  logic [DW-1:0]    ad_i,
    output logic [AW-DW-1:0] addr_hi,
    output logic             ale,
    output logic             rd_n,
    output logic             wr_n,
    output logic [DW-1:0]    ad_keep,
    output logic             ad_keep_en,
    output logic [DW-1:0]    ad_pu
);

    localparam int HW      = AW - DW;
    localparam int MAX_LOW = 3;

    xbus_state_e       state, state_nx;
    logic [1:0]        cnt;
    logic              r_write;
    logic [AW-1:0]     r_addr;
    logic [DW-1:0]     r_wdata;
    ws_plan_t          r_plan;
    ws_plan_t          plan_in;
    logic              accept;
    logic              strb_last;
    logic              capture;

    xbus_sector_sel #(.HW(HW), .SPLIT_EN(SPLIT_EN)) u_sector (
        .addr_hi (req_addr[AW-1:DW]),
        .limit   (cfg_limit),
        .code_lo (cfg_ws_lo),
        .code_hi (cfg_ws_hi),
        .plan    (plan_in)
    );

    always_comb begin
        accept    = (state == S_IDLE) && req_valid;
        strb_last = (state == S_STRB) && (cnt == 2'd0);
        capture   = strb_last && !r_write;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:  if (req_valid) state_nx = S_ADDR;
            S_ADDR:  state_nx = S_LATCH;
            S_LATCH: state_nx = S_STRB;
            S_STRB:  if (cnt == 2'd0) state_nx = r_plan.tail ? S_HOLD : S_DONE;
            S_HOLD:  state_nx = S_DONE;
            S_DONE:  state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            cnt       <= '0;
            r_write   <= 1'b0;
            r_addr    <= '0;
            r_wdata   <= '0;
            r_plan    <= '0;
            req_rdata <= '0;
        end else begin
            state <= state_nx;
            if (accept) begin
                r_write <= req_write;
                r_addr  <= req_addr;
                r_wdata <= req_wdata;
                r_plan  <= plan_in;
            end
            if (state == S_LATCH) begin
                cnt <= r_plan.extra;
            end else if (state == S_STRB && cnt != 2'd0) begin
                cnt <= cnt - 2'd1;
            end
            if (capture) begin
                req_rdata <= ad_i;
            end
        end
    end

    always_comb begin
        ale       = 1'b0;
        rd_n      = 1'b1;
        wr_n      = 1'b1;
        ad_oe     = 1'b0;
        ad_o      = '0;
        req_ready = 1'b0;
        unique case (state)
            S_IDLE: ;
            S_ADDR: begin
                ale   = 1'b1;
                ad_oe = 1'b1;
                ad_o  = r_addr[DW-1:0];
            end
            S_LATCH: begin
                ad_oe = 1'b1;
                ad_o  = r_addr[DW-1:0];
            end
            S_STRB: begin
                if (r_write) begin
                    wr_n  = 1'b0;
                    ad_oe = 1'b1;
                    ad_o  = r_wdata;
                end else begin
                    rd_n = 1'b0;
                end
            end
            S_HOLD: begin
                ad_oe = r_write;
                ad_o  = r_write ? r_wdata : '0;
            end
            S_DONE: begin
                ad_oe     = r_write;
                ad_o      = r_write ? r_wdata : '0;
                req_ready = 1'b1;
            end
            default: ;
        endcase
        addr_hi = r_addr[AW-1:DW];
        ad_pu   = ad_oe ? '0 : cfg_pullup;
    end

    xbus_keeper #(.DW(DW)) u_keeper (
        .clk       (clk),
        .rst_n     (rst_n),
        .drive_en  (ad_oe),
        .drive_val (ad_o),
        .cap_en    (capture),
        .cap_val   (ad_i),
        .keep_en   (cfg_keep_en),
        .hold_val  (ad_keep),
        .hold_en   (ad_keep_en)
    );

    logic [1:0] low_run;
    always_ff @(posedge clk) begin
        if (!rst_n)              low_run <= '0;
        else if (!rd_n || !wr_n) low_run <= low_run + 2'd1;
        else                     low_run <= '0;
    end

    // R2
    ale_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> (ad_oe && rd_n && wr_n));

    // R2
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ale) |-> (ad_oe && $stable(ad_o) && rd_n && wr_n));

    // R3
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> rd_n);

    // R4
    read_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !ad_oe);

    // R5
    strobe_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n || !wr_n) |-> (low_run < 2'(MAX_LOW)));

    // R7
    ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |=> !req_ready);

    // R10
    no_start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ale) |-> $past(state == S_IDLE));

endmodule

// File: tb/xbus_ctrl_tb.sv
module xbus_ctrl_tb;

    typedef struct packed {
        logic        wr;
        logic [15:0] addr;
        logic [7:0]  wdata;
        logic [7:0]  rdin;
        logic [1:0]  lo;
        logic [1:0]  hi;
        logic [7:0]  limit;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 16'h1234, 8'hA5, 8'h00, 2'd0, 2'd3, 8'h20},
        '{1'b0, 16'h2345, 8'h00, 8'h3C, 2'd0, 2'd3, 8'h20},
        '{1'b0, 16'h0001, 8'h00, 8'hC3, 2'd1, 2'd2, 8'h20},
        '{1'b1, 16'h8000, 8'h5A, 8'h00, 2'd1, 2'd2, 8'h80},
        '{1'b0, 16'h7FFF, 8'h00, 8'h96, 2'd3, 2'd0, 8'h80},
        '{1'b1, 16'hFF00, 8'h0F, 8'h00, 2'd2, 2'd1, 8'h00}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0, req_rdata;
    logic        req_ready;
    logic [7:0]  cfg_limit = '0, cfg_pullup = 8'h0F;
    logic [1:0]  cfg_ws_lo = '0, cfg_ws_hi = '0;
    logic        cfg_keep_en = 1'b1;
    logic [7:0]  ad_o, ad_i = '0, addr_hi, ad_keep, ad_pu;
    logic        ad_oe, ale, rd_n, wr_n, ad_keep_en;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    xbus_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .req_rdata(req_rdata), .cfg_limit(cfg_limit), .cfg_ws_lo(cfg_ws_lo),
        .cfg_ws_hi(cfg_ws_hi), .cfg_keep_en(cfg_keep_en), .cfg_pullup(cfg_pullup),
        .ad_o(ad_o), .ad_oe(ad_oe), .ad_i(ad_i), .addr_hi(addr_hi), .ale(ale),
        .rd_n(rd_n), .wr_n(wr_n), .ad_keep(ad_keep), .ad_keep_en(ad_keep_en),
        .ad_pu(ad_pu)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [1:0] pick_code(input vec_t v);
        return (v.addr[15:8] < v.limit) ? v.lo : v.hi;
    endfunction

    // Runs one access; returns latency index of ready, strobe-low count, read data
    task automatic access(input vec_t v, input bit keep_valid, output int lat,
                          output int lowc, output logic [7:0] rd);
        int idx;
        bit done;
        @(negedge clk);
        cfg_limit = v.limit; cfg_ws_lo = v.lo; cfg_ws_hi = v.hi;
        req_write = v.wr; req_addr = v.addr; req_wdata = v.wdata;
        ad_i = v.rdin; req_valid = 1'b1;
        idx = 0; lowc = 0; done = 0; lat = -1; rd = '0;
        while (!done && idx < 20) begin
            @(negedge clk);
            if (idx == 0) begin
                // R2 address phase
                check(ale && ad_oe && ad_o == v.addr[7:0] && addr_hi == v.addr[15:8],
                      "R2", {ale, ad_oe, ad_o, addr_hi}, {2'b11, v.addr[7:0], v.addr[15:8]});
                // R9 pull-ups off while driving
                check(ad_pu == 8'h00, "R9", ad_pu, 0);
            end
            if (idx == 1)
                check(!ale && ad_oe && ad_o == v.addr[7:0], "R2",
                      {ale, ad_oe, ad_o}, {2'b01, v.addr[7:0]});
            if (!wr_n) begin
                lowc++;
                check(v.wr && ad_oe && ad_o == v.wdata, "R3", {ad_oe, ad_o}, {1'b1, v.wdata});
            end
            if (!rd_n) begin
                lowc++;
                check(!v.wr && !ad_oe, "R4", {v.wr, ad_oe}, 0);
            end
            if (req_ready) begin
                done = 1; lat = idx; rd = req_rdata;
                if (!keep_valid) req_valid = 1'b0;
            end
            idx++;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        int lat, lowc, exp_low, exp_lat;
        logic [7:0] rd;
        logic [1:0] code;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(!ale && rd_n && wr_n && !ad_oe && !req_ready, "R1",
              {ale, rd_n, wr_n, ad_oe, req_ready}, 5'b01100);
        rst_n = 1'b1;
        @(negedge clk);
        check(!ale && rd_n && wr_n && !ad_oe && !req_ready, "R1",
              {ale, rd_n, wr_n, ad_oe, req_ready}, 5'b01100);
        // R9 pull-ups follow port while released
        check(ad_pu == cfg_pullup, "R9", ad_pu, cfg_pullup);

        for (int i = 0; i < NV; i++) begin
            code    = pick_code(VECS[i]);
            exp_low = (code == 2'd0) ? 1 : ((code == 2'd1) ? 2 : 3);
            exp_lat = 2 + exp_low + ((code == 2'd3) ? 1 : 0);
            access(VECS[i], 1'b0, lat, lowc, rd);
            // R5 and R6: strobe width from the sector-selected code
            check(lowc == exp_low, "R5/R6", lowc, exp_low);
            // R7 ready timing
            check(lat == exp_lat, "R7", lat, exp_lat);
            if (!VECS[i].wr) check(rd == VECS[i].rdin, "R4", rd, VECS[i].rdin);
            @(negedge clk);
            check(!req_ready, "R7", req_ready, 0);
            // R8 keeper holds last bus value
            check(ad_keep_en && ad_keep == (VECS[i].wr ? VECS[i].wdata : VECS[i].rdin),
                  "R8", ad_keep, VECS[i].wr ? VECS[i].wdata : VECS[i].rdin);
        end

        // R8 keeper disabled
        cfg_keep_en = 1'b0;
        @(negedge clk);
        check(!ad_keep_en, "R8", ad_keep_en, 0);
        cfg_keep_en = 1'b1;
        cfg_pullup = 8'hC3;
        @(negedge clk);
        check(ad_pu == 8'hC3, "R9", ad_pu, 8'hC3);

        // R10 idle stays idle without a request
        repeat (4) @(negedge clk);
        check(!ale && rd_n && wr_n, "R10", {ale, rd_n, wr_n}, 3'b011);

        // R10 back-to-back: second request waits for completion of the first
        access('{1'b1, 16'h0510, 8'h11, 8'h00, 2'd0, 2'd1, 8'h20}, 1'b1, lat, lowc, rd);
        check(lat == 3, "R10", lat, 3);
        req_write = 1'b0; req_addr = 16'h4422; ad_i = 8'h77;
        @(negedge clk);
        check(!ale, "R10", ale, 0);
        @(negedge clk);
        check(ale && ad_o == 8'h22 && addr_hi == 8'h44, "R10", {ale, ad_o}, {1'b1, 8'h22});
        begin
            int k;
            k = 0;
            while (!req_ready && k < 20) begin @(negedge clk); k++; end
            req_valid = 1'b0;
            // R6 upper code 1 -> latency 4 from ale cycle
            check(k == 4, "R6", k, 4);
            check(req_rdata == 8'h77, "R4", req_rdata, 8'h77);
        end

        // R1 reset mid-access returns to idle
        access('{1'b0, 16'h0100, 8'h00, 8'h55, 2'd3, 2'd3, 8'h00}, 1'b0, lat, lowc, rd);
        @(negedge clk);
        req_valid = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b0; req_valid = 1'b0;
        @(negedge clk);
        check(!ale && rd_n && wr_n && !ad_oe && !req_ready, "R1",
              {ale, rd_n, wr_n, ad_oe, req_ready}, 5'b01100);
        rst_n = 1'b1;
        @(negedge clk);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule